// File: doc/BRIEF.md
# Dual-Rank Bus Register with Serial Shifter

The block holds two registers of equal width. The upper rank sits on a bidirectional data bus. It can capture the bus, take the lower rank's contents, or capture the bitwise OR of the two. The lower rank is a serial shift register. It can take the upper rank's contents, swap with the upper rank in a single clock, or shift one place per clock. Shifting runs in the same cycle as any operation on the upper rank.

Five active-low control inputs enable the functions: bus capture, bus drive, raise (lower to upper), lower (upper to lower) and shift. A low level enables its function and a high level disables it. The pad is split into `bus_in`, `bus_out` and `bus_oe`. `bus_out` always carries the upper rank, and `bus_oe` says when the pins should drive it. Several instances chain into a wider shifter by connecting each `ser_out` to the next `ser_in`.

A decoder turns the control levels into one named operation per rank. For the upper rank the operations are HOLD, LOAD, RAISE and MERGE. For the lower rank they are HOLD, LOWER and SHIFT. Each rank moves to its next value on every rising clock edge. That move is HOLD when nothing is enabled for that rank.

Top module: `dual_rank_shifter`

## Requirements
- R1: A synchronous active-high `rst` clears both ranks to zero at the next rising edge, so `bus_out` and `ser_out` read 0.
- R2: With bus capture enabled (`cap_dis_n`=0) and raise disabled (`rais_dis_n`=1), the upper rank takes `bus_in` at the edge (LOAD).
- R3: With raise enabled and bus capture disabled, the upper rank takes the lower rank's value (RAISE).
- R4: With bus capture and raise both enabled, the upper rank takes `bus_in` OR the lower rank, bit by bit (MERGE).
- R5: With lower enabled (`lowr_dis_n`=0), the lower rank takes the upper rank's value from before the edge (LOWER). When raise is also enabled, the two ranks swap in one clock.
- R6: With shift enabled (`shft_dis_n`=0) and lower disabled, the lower rank moves one place toward its MSB. Bit 0 takes `ser_in`. This happens alongside whatever the upper rank does in the same cycle (SHIFT).
- R7: When lower and shift are both enabled, LOWER takes precedence and no shift occurs.
- R8: With every function disabled, both ranks keep their values (HOLD).
- R9: `bus_oe` is 1 only when drive is enabled (`drv_dis_n`=0) and bus capture is disabled. Capture wins over drive.
- R10: `ser_out` is the MSB of the lower rank. The state of `bus_oe` never blocks a load, transfer or shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_in | input | 1 | Serial data into bit 0 of the lower rank |
| cap_dis_n | input | 1 | Bus capture disable, low enables |
| drv_dis_n | input | 1 | Bus drive disable, low enables |
| rais_dis_n | input | 1 | Lower-to-upper transfer disable, low enables |
| lowr_dis_n | input | 1 | Upper-to-lower transfer disable, low enables |
| shft_dis_n | input | 1 | Shift disable, low enables |
| bus_in | input | WIDTH | Value seen on the bus pins |
| bus_out | output | WIDTH | Upper rank, to be driven onto the pins |
| bus_oe | output | 1 | Pin drive enable |
| ser_out | output | 1 | MSB of the lower rank |

## Verification
The properties assume that every control input, `ser_in` and `bus_in` hold defined 0/1 levels at each rising edge. They also assume that `rst` is high on the first edge, so that every `$past` value they sample is defined. The bench meets both assumptions. It asserts reset before the first edge and drives every input at the falling edge, well clear of the sampling edge. It draws random control levels only from full 0/1 vectors, so each of the 32 control combinations can occur, including capture and drive enabled together.

// File: rtl/dual_rank_pkg.sv
package dual_rank_pkg;

    // Operation applied to the upper (bus-side) rank at a clock edge
    typedef enum logic [1:0] {
        UP_HOLD  = 2'd0,
        UP_LOAD  = 2'd1,
        UP_RAISE = 2'd2,
        UP_MERGE = 2'd3
    } upper_op_e;

    // Operation applied to the lower (serial) rank at a clock edge
    typedef enum logic [1:0] {
        LO_HOLD  = 2'd0,
        LO_LOWER = 2'd1,
        LO_SHIFT = 2'd2
    } lower_op_e;

endpackage

// File: rtl/drs_mode_decode.sv
module drs_mode_decode
    import dual_rank_pkg::*;
(
    input  logic      cap_dis_n,
    input  logic      drv_dis_n,
    input  logic      rais_dis_n,
    input  logic      lowr_dis_n,
    input  logic      shft_dis_n,
    output upper_op_e up_op,
    output lower_op_e lo_op,
    output logic      drive_en
);

    logic cap_en;
    logic drv_en;
    logic rais_en;
    logic lowr_en;
    logic shft_en;

    // every control is active low
    always_comb begin
        cap_en  = ~cap_dis_n;
        drv_en  = ~drv_dis_n;
        rais_en = ~rais_dis_n;
        lowr_en = ~lowr_dis_n;
        shft_en = ~shft_dis_n;
    end

    // upper rank: capture and raise together form the merge
    always_comb begin
        unique case ({cap_en, rais_en})
            2'b10:   up_op = UP_LOAD;
            2'b01:   up_op = UP_RAISE;
            2'b11:   up_op = UP_MERGE;
            default: up_op = UP_HOLD;
        endcase
    end

    // lower rank: a parallel transfer outranks the shift
    always_comb begin
        unique case ({lowr_en, shft_en})
            2'b10, 2'b11: lo_op = LO_LOWER;
            2'b01:        lo_op = LO_SHIFT;
            default:      lo_op = LO_HOLD;
        endcase
    end

    // pins act as inputs whenever capture is on
    always_comb begin
        drive_en = drv_en & ~cap_en;
    end

endmodule

// File: rtl/drs_upper_rank.sv
module drs_upper_rank
    import dual_rank_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  upper_op_e        op,
    input  logic [WIDTH-1:0] bus_val,
    input  logic [WIDTH-1:0] lower_val,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] q_nxt;

    always_comb begin
        unique case (op)
            UP_LOAD:  q_nxt = bus_val;
            UP_RAISE: q_nxt = lower_val;
            UP_MERGE: q_nxt = bus_val | lower_val;
            default:  q_nxt = q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= q_nxt;
    end

endmodule

// File: rtl/drs_lower_rank.sv
module drs_lower_rank
    import dual_rank_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  lower_op_e        op,
    input  logic [WIDTH-1:0] upper_val,
    input  logic             ser_in,
    output logic [WIDTH-1:0] q,
    output logic             ser_out
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] shifted;
    logic [WIDTH-1:0] q_nxt;

    // serial data enters bit 0 and walks toward the MSB
    assign shifted[0] = ser_in;
    for (genvar i = 1; i < WIDTH; i++) begin : g_chain
        assign shifted[i] = q[i-1];
    end

    always_comb begin
        unique case (op)
            LO_LOWER: q_nxt = upper_val;
            LO_SHIFT: q_nxt = shifted;
            default:  q_nxt = q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= q_nxt;
    end

    assign ser_out = q[MSB];

endmodule

// File: rtl/dual_rank_shifter.sv
module dual_rank_shifter
    import dual_rank_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ser_in,
    input  logic             cap_dis_n,
    input  logic             drv_dis_n,
    input  logic             rais_dis_n,
    input  logic             lowr_dis_n,
    input  logic             shft_dis_n,
    input  logic [WIDTH-1:0] bus_in,
    output logic [WIDTH-1:0] bus_out,
    output logic             bus_oe,
    output logic             ser_out
);

    upper_op_e        up_op;
    lower_op_e        lo_op;
    logic [WIDTH-1:0] a_q;
    logic [WIDTH-1:0] b_q;

    drs_mode_decode u_decode (
        .cap_dis_n  (cap_dis_n),
        .drv_dis_n  (drv_dis_n),
        .rais_dis_n (rais_dis_n),
        .lowr_dis_n (lowr_dis_n),
        .shft_dis_n (shft_dis_n),
        .up_op      (up_op),
        .lo_op      (lo_op),
        .drive_en   (bus_oe)
    );

    drs_upper_rank #(.WIDTH(WIDTH)) u_upper (
        .clk       (clk),
        .rst       (rst),
        .op        (up_op),
        .bus_val   (bus_in),
        .lower_val (b_q),
        .q         (a_q)
    );

    drs_lower_rank #(.WIDTH(WIDTH)) u_lower (
        .clk       (clk),
        .rst       (rst),
        .op        (lo_op),
        .upper_val (a_q),
        .ser_in    (ser_in),
        .q         (b_q),
        .ser_out   (ser_out)
    );

    assign bus_out = a_q;

endmodule

// File: rtl/drs_checker.sv
module drs_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             ser_in,
    input logic             cap_dis_n,
    input logic             drv_dis_n,
    input logic             rais_dis_n,
    input logic             lowr_dis_n,
    input logic             shft_dis_n,
    input logic [WIDTH-1:0] bus_in,
    input logic             bus_oe,
    input logic             ser_out,
    input logic [WIDTH-1:0] a_q,
    input logic [WIDTH-1:0] b_q
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (a_q == '0 && b_q == '0));

    // R2
    load_chk: assert property (@(posedge clk) disable iff (rst)
        (!cap_dis_n && rais_dis_n) |=> a_q == $past(bus_in));

    // R4
    merge_chk: assert property (@(posedge clk) disable iff (rst)
        (!cap_dis_n && !rais_dis_n) |=> a_q == ($past(bus_in) | $past(b_q)));

    // R5
    swap_chk: assert property (@(posedge clk) disable iff (rst)
        (!rais_dis_n && !lowr_dis_n && cap_dis_n) |=>
            (a_q == $past(b_q) && b_q == $past(a_q)));

    // R6
    shift_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (!shft_dis_n && lowr_dis_n) |=> b_q[0] == $past(ser_in));

    // R7
    lower_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (!shft_dis_n && !lowr_dis_n) |=> b_q == $past(a_q));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cap_dis_n && rais_dis_n && lowr_dis_n && shft_dis_n) |=>
            ($stable(a_q) && $stable(b_q)));

    // R9
    capture_first_chk: assert property (@(posedge clk) disable iff (rst)
        !cap_dis_n |-> !bus_oe);

    // R9
    drive_on_chk: assert property (@(posedge clk) disable iff (rst)
        (!drv_dis_n && cap_dis_n) |-> bus_oe);

    // R10
    serial_out_chk: assert property (@(posedge clk) disable iff (rst)
        (!shft_dis_n && lowr_dis_n) |=> ser_out == $past(b_q[WIDTH-2]));

endmodule

bind dual_rank_shifter drs_checker #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ser_in     (ser_in),
    .cap_dis_n  (cap_dis_n),
    .drv_dis_n  (drv_dis_n),
    .rais_dis_n (rais_dis_n),
    .lowr_dis_n (lowr_dis_n),
    .shft_dis_n (shft_dis_n),
    .bus_in     (bus_in),
    .bus_oe     (bus_oe),
    .ser_out    (ser_out),
    .a_q        (a_q),
    .b_q        (b_q)
);

// File: tb/dual_rank_shifter_test.sv
`timescale 1ns/1ps
module dual_rank_shifter_test;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ser_in = 1'b0;
    logic         cap_dis_n = 1'b1;
    logic         drv_dis_n = 1'b1;
    logic         rais_dis_n = 1'b1;
    logic         lowr_dis_n = 1'b1;
    logic         shft_dis_n = 1'b1;
    logic [W-1:0] bus_in = '0;
    logic [W-1:0] bus_out;
    logic         bus_oe;
    logic         ser_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    logic [W-1:0] ma = '0;
    logic [W-1:0] mb = '0;

    // scoreboard queues
    logic [W-1:0] q_a[$];
    logic         q_so[$];
    logic         q_oe[$];
    string        q_tag[$];

    always #4 clk = ~clk;   // 125 MHz

    dual_rank_shifter #(.WIDTH(W)) uut (
        .clk        (clk),
        .rst        (rst),
        .ser_in     (ser_in),
        .cap_dis_n  (cap_dis_n),
        .drv_dis_n  (drv_dis_n),
        .rais_dis_n (rais_dis_n),
        .lowr_dis_n (lowr_dis_n),
        .shft_dis_n (shft_dis_n),
        .bus_in     (bus_in),
        .bus_out    (bus_out),
        .bus_oe     (bus_oe),
        .ser_out    (ser_out)
    );

    // driver: apply one cycle of stimulus, advance model, queue expectation
    task automatic step(input logic r, input logic cd, input logic dd,
                        input logic ud, input logic ld, input logic sd,
                        input logic si, input logic [W-1:0] bv,
                        input string tag);
        logic [W-1:0] na;
        logic [W-1:0] nb;
        logic         oe;
        @(negedge clk);
        rst = r; cap_dis_n = cd; drv_dis_n = dd; rais_dis_n = ud;
        lowr_dis_n = ld; shft_dis_n = sd; ser_in = si; bus_in = bv;
        if (r) begin
            na = '0; nb = '0;
        end else begin
            na = ma; nb = mb;
            if (!cd && !ud)     na = bv | mb;
            else if (!cd)       na = bv;
            else if (!ud)       na = mb;
            if (!ld)            nb = ma;
            else if (!sd)       nb = {mb[W-2:0], si};
        end
        oe = !dd && cd;
        ma = na; mb = nb;
        q_a.push_back(na); q_so.push_back(nb[W-1]); q_oe.push_back(oe);
        q_tag.push_back(tag);
    endtask

    // monitor: compare just after each edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q_a.size() > 0) begin
                logic [W-1:0] ea;
                logic         eso;
                logic         eoe;
                string        t;
                ea = q_a.pop_front(); eso = q_so.pop_front();
                eoe = q_oe.pop_front(); t = q_tag.pop_front();
                checks++;
                if (bus_out !== ea || ser_out !== eso || bus_oe !== eoe) begin
                    errors++;
                    $display("FAIL %s: bus_out=%h ser_out=%b bus_oe=%b expected %h %b %b",
                             t, bus_out, ser_out, bus_oe, ea, eso, eoe);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1 reset clears both ranks
        step(1, 1,1,1,1,1, 0, 8'hFF, "R1");
        step(1, 0,0,0,0,0, 1, 8'hFF, "R1");
        // R2 load from bus, drive enabled too: R9 capture wins
        step(0, 0,0,1,1,1, 0, 8'hA5, "R2");
        // R5 lower only; R10 ser_out shows MSB of lower rank
        step(0, 1,1,1,0,1, 0, 8'h00, "R5");
        // R9 drive alone enables the pins
        step(0, 1,0,1,1,1, 0, 8'h00, "R9");
        step(0, 0,1,1,1,1, 0, 8'h3C, "R2");
        // R5 swap in one clock
        step(0, 1,1,0,0,1, 0, 8'h00, "R5");
        // R3 raise only
        step(0, 1,1,0,1,1, 0, 8'h00, "R3");
        // R4 merge bus with lower rank
        step(0, 0,1,0,1,1, 0, 8'hC1, "R4");
        // R6 shift a pattern in while upper loads; R10 pins off do not block
        for (int i = 0; i < W; i++)
            step(0, 0,1,1,1,0, logic'(i % 3 == 0), 8'(i * 17), "R6");
        step(0, 1,1,0,1,1, 0, 8'h00, "R6");
        // R7 lower beats shift
        step(0, 0,1,1,1,1, 0, 8'h5A, "R7");
        step(0, 1,1,1,0,0, 1, 8'h00, "R7");
        step(0, 1,1,0,1,1, 0, 8'h00, "R7");
        // R8 everything disabled holds
        step(0, 1,1,1,1,1, 1, 8'hFF, "R8");
        step(0, 1,1,1,1,1, 0, 8'h00, "R8");
        // R10 lower rank walked out through ser_out with pins off
        for (int i = 0; i < W; i++)
            step(0, 1,1,1,1,0, 0, 8'h00, "R10");
        // random control combinations against the model
        for (int i = 0; i < 600; i++) begin
            logic [4:0] c;
            c = 5'($urandom);
            step(($urandom % 50) == 0, c[0], c[1], c[2], c[3], c[4],
                 1'($urandom), 8'($urandom), "R2-R8 random");
        end
        repeat (3) @(posedge clk);
        #3;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule